// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit sits beside a 16550-style serial port and owns its two modem registers: a control register that drives four handshake outputs and selects internal loopback, and a status register that reports four incoming handshake lines together with sticky change flags. Software writes the control register and reads either register through a small host port. Every status-register read clears the change flags, and a single interrupt-request output stays high while any change flag is set.

The external status lines are asynchronous, so each passes through a two-flop synchronizer before change detection. In loopback the status nibble is fed from the control bits instead of the pins: OUT2 appears as DCD, OUT1 as RI, RTS as CTS and DTR as DSR. The pins are ignored and the external RTS and DTR outputs are parked low. The serial data path is not part of this unit.

Top module: `modem_ctl_unit`

## Requirements
- R1: After reset the control register (regSel=0) reads 0x08, the status register (regSel=1) reads 0xB0, out2Out is 1, rtsOut, dtrOut, out1Out and deltaIrq are 0.
- R2: A write with regSel=0 keeps only wrData[4:0], so bits 7..5 read back as zero. Control bit 0 is DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2 and bit 4 loopback. Outside loopback dtrOut, rtsOut, out1Out and out2Out follow bits 0..3 from the edge that takes the write.
- R3: Status bits 7, 6, 5 and 4 report DCD, RI, DSR and CTS. A change on an external line appears there at the third rising edge after it.
- R4: Status bit 3 (DCD), bit 1 (DSR) and bit 0 (CTS) are change flags. Each is set in the same cycle its line bit takes a new value, in either direction.
- R5: Status bit 2 is set only when RI goes from 1 to 0. RI going from 0 to 1 leaves it unchanged.
- R6: A status read returns the current value, and the edge that ends the read clears bits 3..0. deltaIrq is high exactly while any of bits 3..0 is set.
- R7: When a line bit changes at the same edge that ends a status read, its new change flag survives the clear.
- R8: With control bit 4 set, the status nibble takes OUT2 as DCD, OUT1 as RI, RTS as CTS and DTR as DSR, one edge after the control register is written. The external status inputs have no effect.
- R9: With control bit 4 set, rtsOut and dtrOut are 0, while out1Out and out2Out still follow control bits 2 and 3.
- R10: A write with regSel=1 changes neither register. A change flag stays set until a status read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 1 | 0 selects control register, 1 selects status register |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe; clears change flags when regSel=1 |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Selected register value, combinational |
| ctsIn | input | 1 | External clear-to-send line, active high |
| dsrIn | input | 1 | External data-set-ready line, active high |
| dcdIn | input | 1 | External carrier-detect line, active high |
| riIn | input | 1 | External ring-indicator line, active high |
| rtsOut | output | 1 | Request-to-send output |
| dtrOut | output | 1 | Data-terminal-ready output |
| out1Out | output | 1 | General output 1 |
| out2Out | output | 1 | General output 2 |
| deltaIrq | output | 1 | High while any status change flag is set |

## Verification
A stuck or mis-cleared change flag shows on deltaIrq at once and in bits 3..0 of the next status read. A wrong synchronizer depth shifts the cycle in which the line nibble updates, and the bench detects that because it reads a fixed number of edges after each input change. Swapped loopback wiring or a trailing-edge detector that fires on rising RI shows in the first status read after the control register is rewritten. A flag lost in the read-clear race shows as a zero where the bench expects a set bit, one read later.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;
  localparam int DATA_W = 8;
  localparam int CTL_W  = 5;
  localparam int LINE_W = 4;

  // control register bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;

  // line nibble positions (status bits 4..7)
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  localparam logic [LINE_W-1:0] LINE_RST = 4'b1011;
  localparam logic [CTL_W-1:0]  CTL_RST  = 5'b01000;

  typedef struct packed {
    logic wrCtl;
    logic rdStat;
  } hostStrb_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int SW = (STAGES < 1) ? 1 : STAGES;
  logic [SW-1:0][W-1:0] stg;

  generate
    if (SW == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg <= RST_VAL;
        else       stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg <= {SW{RST_VAL}};
        else       stg <= {stg[SW-2:0], d};
      end
    end
  endgenerate

  assign q = stg[SW-1];
endmodule

// File: rtl/mdm_host_ctl.sv
module mdm_host_ctl
  import modem_ctl_pkg::*;
(
  input  logic              regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [CTL_W-1:0]  ctlQ,
  input  logic [DATA_W-1:0] statQ,
  output hostStrb_t         strb,
  output logic [DATA_W-1:0] rdData
);
  always_comb begin
    strb.wrCtl  = wrEn & ~regSel;
    strb.rdStat = rdEn & regSel;
    rdData      = regSel ? statQ : {{(DATA_W-CTL_W){1'b0}}, ctlQ};
  end
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
  import modem_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LINE_W-1:0] extLines,
  output logic [CTL_W-1:0]  ctlQ,
  output logic [DATA_W-1:0] statQ
);
  logic [LINE_W-1:0] syncLines, srcLines, lineQ, deltaQ, setBits, chg;
  logic loopOn;

  mdm_sync #(.W(LINE_W), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
    .clk(clk), .rstN(rstN), .d(extLines), .q(syncLines)
  );

  assign loopOn = ctlQ[C_LOOP];

  always_comb begin
    srcLines = syncLines;
    if (loopOn) begin
      srcLines[L_DCD] = ctlQ[C_OUT2];
      srcLines[L_RI]  = ctlQ[C_OUT1];
      srcLines[L_CTS] = ctlQ[C_RTS];
      srcLines[L_DSR] = ctlQ[C_DTR];
    end
    chg = srcLines ^ lineQ;
    setBits = chg;
    setBits[L_RI] = lineQ[L_RI] & ~srcLines[L_RI];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ   <= CTL_RST;
      lineQ  <= LINE_RST;
      deltaQ <= '0;
    end else begin
      if (strb.wrCtl) ctlQ <= wrData[CTL_W-1:0];
      lineQ  <= srcLines;
      deltaQ <= (strb.rdStat ? '0 : deltaQ) | setBits;
    end
  end

  assign statQ = {lineQ, deltaQ};

  assert_cts_change_R4: assert property (@(posedge clk) disable iff (!rstN)
    (srcLines[L_CTS] != lineQ[L_CTS]) |=> deltaQ[L_CTS]);
  assert_ri_rise_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!lineQ[L_RI] && srcLines[L_RI] && !deltaQ[L_RI]) |=> !deltaQ[L_RI]);
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStat && srcLines == lineQ) |=> (deltaQ == '0));
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (deltaQ[L_DCD] && !strb.rdStat) |=> deltaQ[L_DCD]);
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import modem_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              dcdIn,
  input  logic              riIn,
  output logic              rtsOut,
  output logic              dtrOut,
  output logic              out1Out,
  output logic              out2Out,
  output logic              deltaIrq
);
  hostStrb_t strb;
  logic [CTL_W-1:0]  ctlQ;
  logic [DATA_W-1:0] statQ;
  logic [LINE_W-1:0] extLines;

  always_comb begin
    extLines = '0;
    extLines[L_CTS] = ctsIn;
    extLines[L_DSR] = dsrIn;
    extLines[L_RI]  = riIn;
    extLines[L_DCD] = dcdIn;
  end

  mdm_host_ctl u_ctl (
    .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .ctlQ(ctlQ), .statQ(statQ), .strb(strb), .rdData(rdData)
  );

  mdm_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .extLines(extLines), .ctlQ(ctlQ), .statQ(statQ)
  );

  assign rtsOut   = ctlQ[C_RTS] & ~ctlQ[C_LOOP];
  assign dtrOut   = ctlQ[C_DTR] & ~ctlQ[C_LOOP];
  assign out1Out  = ctlQ[C_OUT1];
  assign out2Out  = ctlQ[C_OUT2];
  assign deltaIrq = |statQ[LINE_W-1:0];

  assert_loop_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctlQ[C_LOOP] |-> (!rtsOut && !dtrOut));
  assert_status_write_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel) |=> $stable(ctlQ));
endmodule

// File: tb/modem_ctl_unit_test.sv
`timescale 1ns/100ps
module modem_ctl_unit_test;
  logic clk = 0, rstN = 0, regSel = 0, wrEn = 0, rdEn = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic ctsIn = 1, dsrIn = 1, dcdIn = 1, riIn = 0;
  logic rtsOut, dtrOut, out1Out, out2Out, deltaIrq;
  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [3:0] cur;   // [3]=DCD [2]=RI [1]=DSR [0]=CTS

  always #2.5 clk = ~clk;

  modem_ctl_unit uut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] deltaOf(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] c;
    c = o ^ n;
    return {c[3], o[2] & ~n[2], c[1], c[0]};
  endfunction

  task automatic setLines(input logic [3:0] v);
    dcdIn = v[3]; riIn = v[2]; dsrIn = v[1]; ctsIn = v[0];
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] v);
    regSel = sel; wrData = v; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
  endtask

  // performs a read; returns value seen before the clearing edge
  task automatic readReg(input logic sel, output logic [7:0] v);
    regSel = sel; rdEn = 1;
    #0.5 v = rdData;
    @(negedge clk);
    rdEn = 0;
  endtask

  initial begin
    int w = 0;
    while (!done && w < 100000) begin @(posedge clk); w++; end
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [3:0] acc;
    void'($urandom(32'd4242));
    waitN(3);
    rstN = 1;
    waitN(1);
    // R1 reset state
    readReg(0, v); chk("R1 ctl", v, 8'h08);
    readReg(1, v); chk("R1 stat", v, 8'hB0);
    chk("R1 pins", {3'b0, out2Out, out1Out, rtsOut, dtrOut, deltaIrq}, 8'h10);

    // R2 write masking and pins
    writeReg(0, 8'hE7);
    readReg(0, v); chk("R2 mask", v, 8'h07);
    chk("R2 pins", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'h07);
    writeReg(0, 8'h0A);
    chk("R2 pins2", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'h0A);

    // R10 status write ignored
    writeReg(1, 8'hFF);
    readReg(0, v); chk("R10 ctl", v, 8'h0A);
    readReg(1, v); chk("R10 stat", v, 8'hB0);

    // R3 latency: change DCD, visible after third edge
    cur = 4'b1011;
    setLines(4'b0011);
    waitN(2);
    regSel = 1; #0.5 chk("R3 not yet", rdData, 8'hB0);
    waitN(1);
    chk("R3 visible", rdData, 8'h38);
    chk("R6 irq", {7'b0, deltaIrq}, 8'h01);
    waitN(3);
    chk("R10 sticky", rdData, 8'h38);
    readReg(1, v); chk("R4 dcd", v, 8'h38);
    #0.5 chk("R6 cleared", rdData, 8'h30);
    chk("R6 irq low", {7'b0, deltaIrq}, 8'h00);
    cur = 4'b0011;

    // R5 rising RI: no trailing flag
    setLines(4'b0111); waitN(4);
    readReg(1, v); chk("R5 rise", v, 8'h70);
    // R5 falling RI: flag set
    setLines(4'b0011); waitN(4);
    readReg(1, v); chk("R5 fall", v, 8'h34);
    cur = 4'b0011;

    // random sequences for R4/R5/R6
    for (int it = 0; it < 40; it++) begin
      int n;
      logic [3:0] nv;
      acc = 0;
      n = 1 + ($urandom % 3);
      for (int k = 0; k < n; k++) begin
        nv = 4'($urandom % 16);
        acc |= deltaOf(cur, nv);
        cur = nv;
        setLines(nv);
        waitN(4);
      end
      chk("R6 irq", {7'b0, deltaIrq}, {7'b0, |acc});
      readReg(1, v); chk("R4/R5 rand", v, {cur, acc});
    end

    // R7 change coincides with read-clear edge
    setLines(cur ^ 4'b0001);
    waitN(2);
    readReg(1, v);
    chk("R7 before", v, {cur, 4'b0000});
    cur = cur ^ 4'b0001;
    readReg(1, v); chk("R7 kept", v, {cur, 4'b0001});

    // R8/R9 loopback: OUT2,RTS,DTR set, OUT1 clear
    writeReg(0, 8'h1B);
    chk("R9 pins", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'h08);
    waitN(1);
    readReg(1, v);
    readReg(1, v); chk("R8 map", v, 8'hB0);
    setLines(~cur); waitN(5);
    readReg(1, v); chk("R8 ignore ext", v, 8'hB0);
    writeReg(0, 8'h14);
    chk("R9 pins2", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'h04);
    waitN(1);
    readReg(1, v); chk("R8 ri rise", v, 8'h4B);
    writeReg(0, 8'h10);
    waitN(1);
    readReg(1, v); chk("R8 ri fall", v, 8'h04);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule